// File: doc/BRIEF.md
# Processor System Control Register Unit

This block keeps the four system-control registers of a processor core: two 8-bit control registers (the condition-code register and the extended mode register) and two 32-bit base registers (the vector base and the short-address base). The instruction decoder hands it one operation per cycle, with a valid strobe, an operation code, a target select, a transfer size and a 32-bit source operand. The source operand is an immediate, a general register or data already read from memory, as routed by the datapath. The block updates its registers on the clock edge that samples the strobe. For store operations it returns the formatted value to write to a general register or memory one cycle later.

The 8-bit registers can move to and from memory as 16-bit words. In that case the register occupies the high byte of the word. The base registers accept long transfers only. Any operation whose size does not match its target, or whose code is unknown, raises a one-cycle illegal-operation flag and leaves every register as it was. The four register values are also driven out continuously, so the rest of the core can use the flags and base addresses.

Top module: `sysctl_regs`

## Requirements
- R1: A synchronous active-low reset sets the condition-code register to 0x80 (interrupt-mask bit 7 set) and clears the extended register, both base registers, `result_valid`, `result_data` and `illegal_op`.
- R2: A load (op code 1) to the condition-code register (target 0) or extended register (target 1) with byte size (size 0) copies `src_data[7:0]` on the edge that samples the strobe.
- R3: A load to target 0 or 1 with word size (size 1) copies `src_data[15:8]`, and `src_data[7:0]` has no effect.
- R4: A store (op code 2) from target 0 or 1 raises `result_valid` for one cycle after the strobe edge. With byte size `result_data` is the register zero-extended. With word size the register is placed in bits 15:8 and every other bit is zero.
- R5: Op codes 3, 4 and 5 apply bitwise AND, OR and XOR of `src_data[7:0]` to target 0 or 1 with byte size, and write the result back to that register.
- R6: A long (size 2) load to the vector base (target 2) or short base (target 3) copies all 32 bits of `src_data`. A long store from them returns all 32 bits in `result_data`.
- R7: Each of the following raises `illegal_op` for exactly one cycle after the strobe edge, with no register change and no `result_valid`: a base target with a size other than long; a target 0 or 1 load or store with long size; a logical op on a base target or with a size other than byte; size code 3; op codes 6 or 7.
- R8: Op code 0 (no operation), and any cycle with `op_valid` low, changes no register and raises neither `result_valid` nor `illegal_op`.
- R9: A store issued in the cycle right after an update of the same register returns the updated value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | 0 none, 1 load, 2 store, 3 AND, 4 OR, 5 XOR |
| op_target | input | 2 | 0 condition code, 1 extended, 2 vector base, 3 short base |
| op_size | input | 2 | 0 byte, 1 word, 2 long |
| src_data | input | 32 | Source operand (immediate, register or memory data) |
| result_data | output | 32 | Formatted store value |
| result_valid | output | 1 | Store value valid, one cycle after the strobe |
| illegal_op | output | 1 | Rejected operation, one cycle after the strobe |
| ccr_q | output | 8 | Condition-code register |
| exr_q | output | 8 | Extended register |
| vbr_q | output | 32 | Vector base register |
| sbr_q | output | 32 | Short base register |

## Verification
Every register is driven out directly, so a wrong update shows on the register outputs in the cycle after the strobe. A wrong byte lane on a word transfer shows in the very next store result as a value in the wrong half of the word. A leak through a rejected operation shows as a register output that moved while `illegal_op` was high in that same cycle. Back-to-back update-then-store pairs expose stale read paths one cycle after the store strobe.

// File: rtl/sysctl_pkg.sv
// Shared encodings for the system control register unit.
// Assumes op, target and size codes are fixed by the instruction decoder.
package sysctl_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_AND   = 3'd3,
        OP_OR    = 3'd4,
        OP_XOR   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        FN_LD_LO = 3'd0,
        FN_LD_HI = 3'd1,
        FN_AND   = 3'd2,
        FN_OR    = 3'd3,
        FN_XOR   = 3'd4
    } ctrl_fn_e;

    typedef enum logic [1:0] {
        FMT_LO   = 2'd0,
        FMT_HI   = 2'd1,
        FMT_FULL = 2'd2
    } store_fmt_e;
endpackage

// File: rtl/sysctl_decode.sv
// Decodes one strobed operation into write enables, an update function,
// a store format and a legality verdict.
// Assumes target bit 1 selects base (1) versus 8-bit control (0) registers,
// and bit 0 selects which register of the pair is addressed.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int NREG = 2
) (
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [1:0]      op_target,
    input  logic [1:0]      op_size,
    output logic [NREG-1:0] ctrl_we,
    output logic [NREG-1:0] base_we,
    output ctrl_fn_e        ctrl_fn,
    output store_fmt_e      store_fmt,
    output logic            store_go,
    output logic            illegal
);
    logic       is_base;
    logic       sel;
    logic       wr_ctrl;
    logic       wr_base;
    logic       st;
    logic       bad;

    assign is_base = op_target[1];
    assign sel     = op_target[0];

    // Classify the operation against its target and size.
    always_comb begin
        wr_ctrl   = 1'b0;
        wr_base   = 1'b0;
        st        = 1'b0;
        bad       = 1'b0;
        ctrl_fn   = FN_LD_LO;
        store_fmt = FMT_FULL;
        case (op_code)
            OP_NOP: ;
            OP_LOAD: begin
                if (is_base) begin
                    if (op_size == SZ_LONG) wr_base = 1'b1;
                    else                    bad = 1'b1;
                end else if (op_size == SZ_BYTE) begin
                    wr_ctrl = 1'b1;
                    ctrl_fn = FN_LD_LO;
                end else if (op_size == SZ_WORD) begin
                    wr_ctrl = 1'b1;
                    ctrl_fn = FN_LD_HI;
                end else begin
                    bad = 1'b1;
                end
            end
            OP_STORE: begin
                if (is_base) begin
                    if (op_size == SZ_LONG) st = 1'b1;
                    else                    bad = 1'b1;
                end else if (op_size == SZ_BYTE) begin
                    st        = 1'b1;
                    store_fmt = FMT_LO;
                end else if (op_size == SZ_WORD) begin
                    st        = 1'b1;
                    store_fmt = FMT_HI;
                end else begin
                    bad = 1'b1;
                end
            end
            OP_AND, OP_OR, OP_XOR: begin
                if (!is_base && op_size == SZ_BYTE) begin
                    wr_ctrl = 1'b1;
                    ctrl_fn = (op_code == OP_AND) ? FN_AND :
                              (op_code == OP_OR)  ? FN_OR  : FN_XOR;
                end else begin
                    bad = 1'b1;
                end
            end
            default: bad = 1'b1;
        endcase
    end

    // Gate the per-register strobes with the valid strobe.
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            ctrl_we[i] = op_valid && wr_ctrl && (sel == i[0]);
            base_we[i] = op_valid && wr_base && (sel == i[0]);
        end
    end

    assign store_go = op_valid && st;
    assign illegal  = op_valid && bad;
endmodule

// File: rtl/sysctl_ctrl_reg.sv
// One narrow control register with load (low or high lane) and logical update.
// Assumes the source operand carries at least two register widths.
module sysctl_ctrl_reg
    import sysctl_pkg::*;
#(
    parameter int          CW      = 8,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  ctrl_fn_e      fn,
    input  logic [2*CW-1:0] src,
    output logic [CW-1:0] q
);
    logic [CW-1:0] nxt;

    // Select the next value from the requested function.
    always_comb begin
        case (fn)
            FN_LD_LO: nxt = src[CW-1:0];
            FN_LD_HI: nxt = src[2*CW-1:CW];
            FN_AND:   nxt = q & src[CW-1:0];
            FN_OR:    nxt = q | src[CW-1:0];
            FN_XOR:   nxt = q ^ src[CW-1:0];
            default:  nxt = q;
        endcase
    end

    // Hold the register, reset to its own value.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= nxt;
    end
endmodule

// File: rtl/sysctl_base_reg.sv
// One wide base register, written whole from the source operand.
// Assumes only long transfers reach it.
module sysctl_base_reg #(
    parameter int BW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [BW-1:0] d,
    output logic [BW-1:0] q
);
    // Hold the register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/sysctl_regs.sv
// System control register unit: two narrow control registers and two wide
// base registers, with load, store and immediate logic operations.
// Assumes one operation per strobe; results and flags appear one cycle later.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter int           CW     = 8,
    parameter int           BW     = 32,
    parameter int           DW     = 32,
    parameter logic [CW-1:0] CC_RST = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [1:0]    op_target,
    input  logic [1:0]    op_size,
    input  logic [DW-1:0] src_data,
    output logic [DW-1:0] result_data,
    output logic          result_valid,
    output logic          illegal_op,
    output logic [CW-1:0] ccr_q,
    output logic [CW-1:0] exr_q,
    output logic [BW-1:0] vbr_q,
    output logic [BW-1:0] sbr_q
);
    localparam int NREG = 2;
    localparam int WW   = 2 * CW;

    logic [NREG-1:0] ctrl_we;
    logic [NREG-1:0] base_we;
    ctrl_fn_e        ctrl_fn;
    store_fmt_e      store_fmt;
    logic            store_go;
    logic            illegal;
    logic [CW-1:0]   ctrl_q [NREG];
    logic [BW-1:0]   base_q [NREG];
    logic [DW-1:0]   fmt_val;

    sysctl_decode #(.NREG(NREG)) u_dec (
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_target(op_target),
        .op_size  (op_size),
        .ctrl_we  (ctrl_we),
        .base_we  (base_we),
        .ctrl_fn  (ctrl_fn),
        .store_fmt(store_fmt),
        .store_go (store_go),
        .illegal  (illegal)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_ctrl
        sysctl_ctrl_reg #(
            .CW     (CW),
            .RST_VAL((i == 0) ? CC_RST : '0)
        ) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (ctrl_we[i]),
            .fn   (ctrl_fn),
            .src  (src_data[WW-1:0]),
            .q    (ctrl_q[i])
        );
    end

    for (genvar i = 0; i < NREG; i++) begin : g_base
        sysctl_base_reg #(.BW(BW)) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (base_we[i]),
            .d    (src_data[BW-1:0]),
            .q    (base_q[i])
        );
    end

    // Read the addressed register and lay it out for the store size.
    always_comb begin
        fmt_val = '0;
        case (store_fmt)
            FMT_LO:   fmt_val[CW-1:0]  = ctrl_q[op_target[0]];
            FMT_HI:   fmt_val[WW-1:CW] = ctrl_q[op_target[0]];
            default:  fmt_val[BW-1:0]  = base_q[op_target[0]];
        endcase
    end

    // Register the store result and the rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_data  <= '0;
            result_valid <= 1'b0;
            illegal_op   <= 1'b0;
        end else begin
            result_valid <= store_go;
            illegal_op   <= illegal;
            if (store_go) result_data <= fmt_val;
        end
    end

    assign ccr_q = ctrl_q[0];
    assign exr_q = ctrl_q[1];
    assign vbr_q = base_q[0];
    assign sbr_q = base_q[1];
endmodule

// File: rtl/sysctl_regs_chk.sv
// Property checker for the system control register unit, bound to its top.
// Assumes it sees only the top-level ports.
module sysctl_regs_chk #(
    parameter int           CW     = 8,
    parameter int           BW     = 32,
    parameter int           DW     = 32,
    parameter logic [CW-1:0] CC_RST = 8'h80
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [2:0]    op_code,
    input logic [1:0]    op_target,
    input logic [1:0]    op_size,
    input logic [DW-1:0] src_data,
    input logic [DW-1:0] result_data,
    input logic          result_valid,
    input logic          illegal_op,
    input logic [CW-1:0] ccr_q,
    input logic [CW-1:0] exr_q,
    input logic [BW-1:0] vbr_q,
    input logic [BW-1:0] sbr_q
);
    logic rst_q = 1'b0;

    // Check the state left by a reset edge on the following edge.
    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_vals_R1: assert (ccr_q == CC_RST && exr_q == '0 &&
                vbr_q == '0 && sbr_q == '0 && !result_valid && !illegal_op &&
                result_data == '0)
                else $error("reset state wrong");
        end
        rst_q <= !rst_n;
    end

    assert_illegal_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> ($stable(ccr_q) && $stable(exr_q) && $stable(vbr_q) &&
                        $stable(sbr_q) && !result_valid));

    assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_valid)) |->
        ($stable(ccr_q) && $stable(exr_q) && $stable(vbr_q) && $stable(sbr_q) &&
         !result_valid && !illegal_op));

    assert_store_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(op_valid) && $past(op_code) == 3'd2));

    assert_and_ccr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && $past(op_code) == 3'd3 &&
         $past(op_target) == 2'd0 && $past(op_size) == 2'd0) |->
        (ccr_q == ($past(ccr_q) & $past(src_data[CW-1:0]))));

    assert_base_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_valid) && $past(op_code) == 3'd1 &&
         $past(op_target) == 2'd2 && $past(op_size) == 2'd2) |->
        (vbr_q == $past(src_data[BW-1:0])));
endmodule

bind sysctl_regs sysctl_regs_chk #(.CW(CW), .BW(BW), .DW(DW), .CC_RST(CC_RST)) u_chk (.*);

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  op_target = '0;
    logic [1:0]  op_size = '0;
    logic [31:0] src_data = '0;
    logic [31:0] result_data;
    logic        result_valid;
    logic        illegal_op;
    logic [7:0]  ccr_q;
    logic [7:0]  exr_q;
    logic [31:0] vbr_q;
    logic [31:0] sbr_q;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sysctl_regs u_sysctl_regs (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_target(op_target), .op_size(op_size), .src_data(src_data),
        .result_data(result_data), .result_valid(result_valid),
        .illegal_op(illegal_op), .ccr_q(ccr_q), .exr_q(exr_q),
        .vbr_q(vbr_q), .sbr_q(sbr_q)
    );

    // Vector: op, target, size, src, expected result, expected illegal, ccr, exr
    localparam int NV = 21;
    localparam logic [87:0] VECS [NV] = '{
        {3'd1, 2'd0, 2'd0, 32'h1234_56A5, 32'h0,         1'b0, 8'hA5, 8'h00}, // R2
        {3'd2, 2'd0, 2'd1, 32'h0,         32'h0000_A500, 1'b0, 8'hA5, 8'h00}, // R4 word
        {3'd1, 2'd1, 2'd1, 32'h0000_3CFF, 32'h0,         1'b0, 8'hA5, 8'h3C}, // R3
        {3'd2, 2'd1, 2'd0, 32'h0,         32'h0000_003C, 1'b0, 8'hA5, 8'h3C}, // R4 byte
        {3'd3, 2'd0, 2'd0, 32'hFFFF_FF0F, 32'h0,         1'b0, 8'h05, 8'h3C}, // R5 and
        {3'd2, 2'd0, 2'd0, 32'h0,         32'h0000_0005, 1'b0, 8'h05, 8'h3C}, // R9
        {3'd4, 2'd1, 2'd0, 32'h0000_0081, 32'h0,         1'b0, 8'h05, 8'hBD}, // R5 or
        {3'd5, 2'd0, 2'd0, 32'h0000_00FF, 32'h0,         1'b0, 8'hFA, 8'hBD}, // R5 xor
        {3'd1, 2'd2, 2'd2, 32'hDEAD_BEEF, 32'h0,         1'b0, 8'hFA, 8'hBD}, // R6
        {3'd2, 2'd2, 2'd2, 32'h0,         32'hDEAD_BEEF, 1'b0, 8'hFA, 8'hBD}, // R6 R9
        {3'd1, 2'd3, 2'd2, 32'h0000_FF00, 32'h0,         1'b0, 8'hFA, 8'hBD}, // R6
        {3'd2, 2'd3, 2'd2, 32'h0,         32'h0000_FF00, 1'b0, 8'hFA, 8'hBD}, // R6
        {3'd1, 2'd2, 2'd1, 32'h0000_0001, 32'h0,         1'b1, 8'hFA, 8'hBD}, // R7
        {3'd2, 2'd2, 2'd2, 32'h0,         32'hDEAD_BEEF, 1'b0, 8'hFA, 8'hBD}, // R7
        {3'd1, 2'd0, 2'd2, 32'h0,         32'h0,         1'b1, 8'hFA, 8'hBD}, // R7
        {3'd3, 2'd2, 2'd0, 32'h0,         32'h0,         1'b1, 8'hFA, 8'hBD}, // R7
        {3'd3, 2'd0, 2'd1, 32'h0,         32'h0,         1'b1, 8'hFA, 8'hBD}, // R7
        {3'd0, 2'd0, 2'd0, 32'h0,         32'h0,         1'b0, 8'hFA, 8'hBD}, // R8
        {3'd6, 2'd0, 2'd0, 32'h0,         32'h0,         1'b1, 8'hFA, 8'hBD}, // R7
        {3'd1, 2'd1, 2'd3, 32'h0,         32'h0,         1'b1, 8'hFA, 8'hBD}, // R7
        {3'd2, 2'd1, 2'd1, 32'h0,         32'h0000_BD00, 1'b0, 8'hFA, 8'hBD}  // R4
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_reset(input string tag);
        chk(ccr_q == 8'h80, tag, {24'h0, ccr_q}, 32'h80);
        chk(exr_q == 8'h00, tag, {24'h0, exr_q}, 32'h0);
        chk(vbr_q == 32'h0 && sbr_q == 32'h0, tag, vbr_q | sbr_q, 32'h0);
        chk(!result_valid && !illegal_op, tag, {30'h0, result_valid, illegal_op}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_reset("R1 after release");

        // Table walk, back-to-back strobes.
        for (int v = 0; v < NV; v++) begin
            logic [87:0] e;
            logic        exp_rv;
            e = VECS[v];
            op_valid  = 1'b1;
            op_code   = e[87:85];
            op_target = e[84:83];
            op_size   = e[82:81];
            src_data  = e[80:49];
            @(negedge clk);
            exp_rv = (e[87:85] == 3'd2) && !e[16];
            chk(illegal_op == e[16], "R7 illegal flag", {31'h0, illegal_op}, {31'h0, e[16]});
            chk(result_valid == exp_rv, "R4 result_valid", {31'h0, result_valid}, {31'h0, exp_rv});
            if (exp_rv)
                chk(result_data == e[48:17], "R4 R6 R9 result", result_data, e[48:17]);
            chk(ccr_q == e[15:8], "R2 R3 R5 ccr", {24'h0, ccr_q}, {24'h0, e[15:8]});
            chk(exr_q == e[7:0], "R2 R3 R5 exr", {24'h0, exr_q}, {24'h0, e[7:0]});
        end
        chk(vbr_q == 32'hDEAD_BEEF, "R6 R7 vbr", vbr_q, 32'hDEAD_BEEF);
        chk(sbr_q == 32'h0000_FF00, "R6 sbr", sbr_q, 32'h0000_FF00);

        // Idle with garbage inputs: nothing moves.
        op_valid  = 1'b0;
        op_code   = 3'd1;
        op_target = 2'd2;
        op_size   = 2'd2;
        src_data  = 32'h5555_5555;
        repeat (2) @(negedge clk);
        chk(vbr_q == 32'hDEAD_BEEF, "R8 idle vbr", vbr_q, 32'hDEAD_BEEF);
        chk(ccr_q == 8'hFA, "R8 idle ccr", {24'h0, ccr_q}, 32'hFA);
        chk(!result_valid && !illegal_op, "R8 idle flags",
            {30'h0, result_valid, illegal_op}, 32'h0);

        // Byte load with high bits set, then word load ignoring low bits.
        op_valid = 1'b1; op_code = 3'd1; op_target = 2'd0; op_size = 2'd0;
        src_data = 32'hFFFF_FF3E;
        @(negedge clk);
        chk(ccr_q == 8'h3E, "R2 byte lane", {24'h0, ccr_q}, 32'h3E);
        op_size = 2'd1; src_data = 32'h0000_C7AA;
        @(negedge clk);
        chk(ccr_q == 8'hC7, "R3 word lane", {24'h0, ccr_q}, 32'hC7);
        op_code = 3'd7; op_size = 2'd0;
        @(negedge clk);
        chk(illegal_op && ccr_q == 8'hC7, "R7 op 7", {24'h0, ccr_q}, 32'hC7);
        op_valid = 1'b0;
        @(negedge clk);
        chk(!illegal_op, "R7 one-cycle flag", {31'h0, illegal_op}, 32'h0);

        // Reset mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule